// File: doc/BRIEF.md
# Power-of-Two Block Allocator

The block hands out and takes back pieces of a 16 KiB memory pool. Every piece has a size of 64 bytes times a power of two and starts at an address that is a multiple of its own size. An allocation request carries a byte count. The block rounds the count up to the nearest allowed size, finds a free piece of that size or breaks a bigger one down, and returns the start address and size class of the piece.

A release request carries an address and a size class. The block returns the piece to the pool. It then joins the piece with its equal-sized neighbour (the piece whose address differs only in the size bit) for as long as that neighbour is also free. Free space is tracked by one bitmap per size class. Both the request side and the response side use valid/ready handshakes, and only one request is in flight at a time.

Size classes run from 0 (64 B) to 8 (16 KiB). A block of class k at address A has index A >> (6+k) in its bitmap.

Top module: `buddy_alloc`

## Requirements
- R1: An allocation of n bytes, with 1 <= n <= 16384, returns class k, the smallest k with 64*2^k >= n. The returned address is a multiple of 64*2^k, and the response has rspOk=1 and rspErr=0.
- R2: An allocation of 0 bytes, or of more than 16384 bytes, is refused with rspOk=0 and rspErr=0. The free state does not change.
- R3: The block is taken from the smallest class at or above the target that has a free block. Within that class, the lowest address is taken. Each split keeps the lower half and marks the upper half free one class down.
- R4: When no class at or above the target has a free block, the allocation is refused with rspOk=0 and rspErr=0, and the free state does not change.
- R5: A release marks the block free. While the class is below 8 and the neighbour at address XOR 64*2^k is free at the same class, the two are joined into one block of the next class at the lower address. The response has rspOk=1 and reports the final address and class.
- R6: Releasing a block whose bit is already set at that class gives rspErr=1 and rspOk=0, and changes nothing.
- R7: A release with class above 8, or with an address that is not a multiple of its block size, gives rspErr=1 and rspOk=0, and changes nothing.
- R8: reqReady is high only when no request is being processed or answered. A response stays valid with stable fields until rspReady is high at a clock edge.
- R9: After reset, the whole pool is a single free class-8 block at address 0, reqReady is 1 and rspValid is 0.
- R10: rspValid becomes visible after the clock edge that is s edges after the accepting edge. For an allocation, s is the number of splits. For a successful release, s is the number of joins plus one. For a refused request, s is 0.
- R11: When rspOk is 0, rspAddr and rspOrder read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqIsFree | input | 1 | 1 = release, 0 = allocate |
| reqSize | input | 16 | Byte count for an allocation |
| reqAddr | input | 14 | Block address for a release |
| reqOrder | input | 4 | Size class for a release |
| rspValid | output | 1 | Response present |
| rspReady | input | 1 | Response consumer ready |
| rspOk | output | 1 | Request succeeded |
| rspErr | output | 1 | Release rejected (duplicate or malformed) |
| rspAddr | output | 14 | Allocated address, or final joined address of a release |
| rspOrder | output | 4 | Class of the returned or joined block |

## Verification
Allocation is driven from an empty pool with a byte count that forces six splits in a row. It is then driven with small counts that are served from split leftovers, which separates the lowest-class-first search from a direct split of the pool. Releases are issued in an order that gives no join, then one join, then a chain of six joins back to the whole pool. Every response latency is compared against the split or join count, which exposes a skipped or extra step. Refused allocations (zero size, oversize, exhausted pool) and bad releases (duplicate, misaligned, out-of-range class) are each followed by a request whose exact result shows whether state leaked. One response is held back with rspReady low to show that it stays stable.

// File: rtl/buddy_pkg.sv
package buddy_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic ldAlloc;    // take found block, load current block registers
    logic ldFree;     // load current block from the release request
    logic splitStep;  // halve current block, free the upper half
    logic mergeStep;  // absorb free neighbour, move one class up
    logic setCur;     // mark current block free
  } buddyStrobe_t;

  // Conditions reported by the datapath
  typedef struct packed {
    logic sizeBad;
    logic allocFound;
    logic allocDirect;
    logic freeBad;
    logic freeDup;
    logic lastSplit;
    logic buddyFree;
  } buddyFlags_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPLIT = 2'd1,
    ST_MERGE = 2'd2,
    ST_RESP  = 2'd3
  } buddyState_t;

endpackage

// File: rtl/buddy_dp.sv
module buddy_dp
  import buddy_pkg::*;
#(
  parameter int POOL_BYTES = 16384,
  parameter int MIN_BYTES  = 64,
  localparam int ADDR_W = $clog2(POOL_BYTES),
  localparam int MIN_W  = $clog2(MIN_BYTES),
  localparam int NORD   = ADDR_W - MIN_W + 1,
  localparam int MAXBLK = POOL_BYTES / MIN_BYTES,
  localparam int IDX_W  = $clog2(MAXBLK),
  localparam int ORD_W  = $clog2(NORD),
  localparam int SIZE_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  buddyStrobe_t      strobe,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ORD_W-1:0]  reqOrder,
  output buddyFlags_t       flags,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ORD_W-1:0]  curOrdOut
);

  localparam logic [ORD_W-1:0] TOP_ORD = ORD_W'(NORD - 1);

  // One free bitmap per class; class k uses the low MAXBLK>>k bits
  logic [NORD-1:0][MAXBLK-1:0] freeMap;
  logic [ORD_W-1:0] curOrd, tgtOrd;
  logic [IDX_W-1:0] curIdx;

  logic [NORD-1:0]  hasFree;
  logic [ORD_W-1:0] reqTgt, foundOrd, ordSafe;
  logic [IDX_W-1:0] foundIdx, freeIdx;
  logic             found, misAligned;
  logic [ADDR_W:0]  alignMask;

  generate
    for (genvar k = 0; k < NORD; k++) begin : g_any
      assign hasFree[k] = |freeMap[k];
    end
  endgenerate

  // Target class: smallest class whose size covers the request
  always_comb begin
    reqTgt = TOP_ORD;
    for (int k = NORD - 1; k >= 0; k--) begin
      if (reqSize <= (SIZE_W'(MIN_BYTES) << k)) reqTgt = ORD_W'(k);
    end
  end

  // Smallest non-empty class at or above target, then lowest index in it
  always_comb begin
    found    = 1'b0;
    foundOrd = '0;
    for (int k = NORD - 1; k >= 0; k--) begin
      if (ORD_W'(k) >= reqTgt && hasFree[k]) begin
        found    = 1'b1;
        foundOrd = ORD_W'(k);
      end
    end
    foundIdx = '0;
    for (int i = MAXBLK - 1; i >= 0; i--) begin
      if (freeMap[foundOrd][i]) foundIdx = IDX_W'(i);
    end
  end

  // Release request decoding
  always_comb begin
    alignMask  = ((ADDR_W+1)'(MIN_BYTES) << reqOrder) - 1'b1;
    misAligned = |(reqAddr & alignMask[ADDR_W-1:0]);
    ordSafe    = (reqOrder > TOP_ORD) ? '0 : reqOrder;
    freeIdx    = IDX_W'(reqAddr >> (MIN_W + ordSafe));
  end

  always_comb begin
    flags.sizeBad     = (reqSize == '0) || (reqSize > SIZE_W'(POOL_BYTES));
    flags.allocFound  = found;
    flags.allocDirect = (foundOrd == reqTgt);
    flags.freeBad     = (reqOrder > TOP_ORD) || misAligned;
    flags.freeDup     = freeMap[ordSafe][freeIdx];
    flags.lastSplit   = (curOrd == tgtOrd + 1'b1);
    flags.buddyFree   = (curOrd < TOP_ORD) && freeMap[curOrd][curIdx ^ IDX_W'(1)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freeMap             <= '0;
      freeMap[NORD-1][0]  <= 1'b1;
      curOrd              <= '0;
      curIdx              <= '0;
      tgtOrd              <= '0;
    end else begin
      if (strobe.ldAlloc) begin
        freeMap[foundOrd][foundIdx] <= 1'b0;
        curOrd <= foundOrd;
        curIdx <= foundIdx;
        tgtOrd <= reqTgt;
      end
      if (strobe.ldFree) begin
        curOrd <= reqOrder;
        curIdx <= freeIdx;
      end
      if (strobe.splitStep) begin
        freeMap[curOrd - 1'b1][(curIdx << 1) | IDX_W'(1)] <= 1'b1;
        curOrd <= curOrd - 1'b1;
        curIdx <= curIdx << 1;
      end
      if (strobe.mergeStep) begin
        freeMap[curOrd][curIdx ^ IDX_W'(1)] <= 1'b0;
        curOrd <= curOrd + 1'b1;
        curIdx <= curIdx >> 1;
      end
      if (strobe.setCur) freeMap[curOrd][curIdx] <= 1'b1;
    end
  end

  assign curAddr   = ADDR_W'(curIdx) << (MIN_W + curOrd);
  assign curOrdOut = curOrd;

endmodule

// File: rtl/buddy_ctrl.sv
module buddy_ctrl
  import buddy_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         reqIsFree,
  input  logic         rspReady,
  input  buddyFlags_t  flags,
  output buddyStrobe_t strobe,
  output logic         reqReady,
  output logic         rspValid,
  output logic         okQ,
  output logic         errQ
);

  buddyState_t state, stateN;
  logic okN, errN;

  always_comb begin
    strobe = '0;
    stateN = state;
    okN    = okQ;
    errN   = errQ;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        if (!reqIsFree) begin
          errN = 1'b0;
          if (flags.sizeBad || !flags.allocFound) begin
            okN    = 1'b0;
            stateN = ST_RESP;
          end else begin
            okN            = 1'b1;
            strobe.ldAlloc = 1'b1;
            stateN         = flags.allocDirect ? ST_RESP : ST_SPLIT;
          end
        end else if (flags.freeBad || flags.freeDup) begin
          okN    = 1'b0;
          errN   = 1'b1;
          stateN = ST_RESP;
        end else begin
          okN           = 1'b1;
          errN          = 1'b0;
          strobe.ldFree = 1'b1;
          stateN        = ST_MERGE;
        end
      end
      ST_SPLIT: begin
        strobe.splitStep = 1'b1;
        if (flags.lastSplit) stateN = ST_RESP;
      end
      ST_MERGE: begin
        if (flags.buddyFree) strobe.mergeStep = 1'b1;
        else begin
          strobe.setCur = 1'b1;
          stateN        = ST_RESP;
        end
      end
      ST_RESP: if (rspReady) stateN = ST_IDLE;
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      okQ   <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      state <= stateN;
      okQ   <= okN;
      errQ  <= errN;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);

endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc
  import buddy_pkg::*;
#(
  parameter int POOL_BYTES = 16384,
  parameter int MIN_BYTES  = 64,
  localparam int ADDR_W = $clog2(POOL_BYTES),
  localparam int MIN_W  = $clog2(MIN_BYTES),
  localparam int NORD   = ADDR_W - MIN_W + 1,
  localparam int ORD_W  = $clog2(NORD),
  localparam int SIZE_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqIsFree,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ORD_W-1:0]  reqOrder,
  output logic              rspValid,
  input  logic              rspReady,
  output logic              rspOk,
  output logic              rspErr,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [ORD_W-1:0]  rspOrder
);

  buddyStrobe_t     strobe;
  buddyFlags_t      flags;
  logic [ADDR_W-1:0] curAddr;
  logic [ORD_W-1:0]  curOrd;

  buddy_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqIsFree(reqIsFree),
    .rspReady(rspReady), .flags(flags), .strobe(strobe),
    .reqReady(reqReady), .rspValid(rspValid), .okQ(rspOk), .errQ(rspErr)
  );

  buddy_dp #(.POOL_BYTES(POOL_BYTES), .MIN_BYTES(MIN_BYTES)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqOrder(reqOrder), .flags(flags),
    .curAddr(curAddr), .curOrdOut(curOrd)
  );

  assign rspAddr  = rspOk ? curAddr : '0;
  assign rspOrder = rspOk ? curOrd  : '0;

endmodule

// File: rtl/buddy_alloc_chk.sv
module buddy_alloc_chk #(
  parameter int POOL_BYTES = 16384,
  parameter int MIN_BYTES  = 64,
  localparam int ADDR_W = $clog2(POOL_BYTES),
  localparam int MIN_W  = $clog2(MIN_BYTES),
  localparam int NORD   = ADDR_W - MIN_W + 1,
  localparam int ORD_W  = $clog2(NORD)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspReady,
  input logic              rspOk,
  input logic              rspErr,
  input logic [ADDR_W-1:0] rspAddr,
  input logic [ORD_W-1:0]  rspOrder
);

  logic [ADDR_W:0] chkMask;
  assign chkMask = ((ADDR_W+1)'(MIN_BYTES) << rspOrder) - 1'b1;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && !rspReady |=> rspValid && $stable(rspAddr) && $stable(rspOk) && $stable(rspErr)); // R8

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> !reqReady); // R8

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && rspOk |-> (rspAddr & chkMask[ADDR_W-1:0]) == '0); // R1

  AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> !(rspOk && rspErr)); // R6

  AST_ORDER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && rspOk |-> rspOrder <= ORD_W'(NORD - 1)); // R5

  AST_FAIL_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && !rspOk |-> rspAddr == '0 && rspOrder == '0); // R11

endmodule

bind buddy_alloc buddy_alloc_chk #(.POOL_BYTES(POOL_BYTES), .MIN_BYTES(MIN_BYTES)) chk_i (
  .clk(clk), .rst_n(rst_n), .reqReady(reqReady), .rspValid(rspValid),
  .rspReady(rspReady), .rspOk(rspOk), .rspErr(rspErr),
  .rspAddr(rspAddr), .rspOrder(rspOrder)
);

// File: tb/buddy_alloc_tb_top.sv
module buddy_alloc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0, reqIsFree = 1'b0, rspReady = 1'b1;
  logic [15:0] reqSize = '0;
  logic [13:0] reqAddr = '0;
  logic [3:0]  reqOrder = '0;
  logic        reqReady, rspValid, rspOk, rspErr;
  logic [13:0] rspAddr;
  logic [3:0]  rspOrder;

  int nChecks = 0, nFails = 0, cycle = 0;
  bit done = 0;

  typedef struct {
    bit    ok, err, stall;
    int    addr, ord, lat, acc;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  buddy_alloc dut_i (.*);

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    nChecks++;
    if (!cond) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: pushes the expected result before the accepting edge
  task automatic issue(input bit isFree, input int size, input int addr, input int ord,
                       input bit eOk, input bit eErr, input int eAddr, input int eOrd,
                       input int eLat, input bit stall, input string tag);
    exp_t e;
    @(negedge clk);
    reqIsFree = isFree;
    reqSize   = 16'(size);
    reqAddr   = 14'(addr);
    reqOrder  = 4'(ord);
    reqValid  = 1'b1;
    while (!reqReady) @(negedge clk);
    e.ok = eOk; e.err = eErr; e.addr = eAddr; e.ord = eOrd; e.lat = eLat;
    e.stall = stall; e.acc = cycle + 1; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rspValid) begin
        if (expQ.size() == 0) check(1'b0, "unexpected response", 1, 0);
        else begin
          exp_t e;
          int holdAddr;
          e = expQ.pop_front();
          check(rspOk == e.ok, {e.tag, " ok"}, int'(rspOk), int'(e.ok));
          check(rspErr == e.err, {e.tag, " err"}, int'(rspErr), int'(e.err));
          check(int'(rspAddr) == e.addr, {e.tag, " addr"}, int'(rspAddr), e.addr);
          check(int'(rspOrder) == e.ord, {e.tag, " order"}, int'(rspOrder), e.ord);
          check(cycle - e.acc == e.lat, {e.tag, " latency R10"}, cycle - e.acc, e.lat);
          if (e.stall) begin
            holdAddr  = int'(rspAddr);
            rspReady  = 1'b0;
            repeat (3) @(negedge clk);
            check(rspValid && int'(rspAddr) == holdAddr && !reqReady,
                  "R8 response held while rspReady low", int'(rspAddr), holdAddr);
            rspReady = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", cycle, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && rspValid == 1'b0, "R9 reset handshake state", int'(reqReady), 1);

    // R1 R3 R9: 200 B from full pool: class 2 at 0, six splits
    issue(0, 200, 0, 0, 1, 0, 0, 2, 6, 0, "R1 R3 R9 alloc 200");
    // R3: smallest non-empty class is 2 (256@256), two splits
    issue(0, 64, 0, 0, 1, 0, 256, 0, 2, 0, "R3 alloc 64 from leftover");
    issue(0, 100, 0, 0, 1, 0, 384, 1, 0, 0, "R1 R3 alloc 100 direct");
    issue(0, 1, 0, 0, 1, 0, 320, 0, 0, 0, "R1 R3 alloc 1 direct");
    // R5: neighbour 256 busy -> no join
    issue(1, 0, 320, 0, 1, 0, 320, 0, 1, 0, "R5 release 320 no join");
    issue(1, 0, 320, 0, 0, 1, 0, 0, 0, 0, "R6 duplicate release");
    issue(1, 0, 256, 0, 1, 0, 256, 1, 2, 0, "R5 release 256 one join");
    issue(1, 0, 100, 0, 0, 1, 0, 0, 0, 0, "R7 misaligned release");
    issue(1, 0, 0, 9, 0, 1, 0, 0, 0, 0, "R7 class out of range");
    issue(1, 0, 384, 1, 1, 0, 256, 2, 2, 0, "R5 release 384 joins");
    issue(1, 0, 0, 2, 1, 0, 0, 8, 7, 0, "R5 release 0 chain to pool");
    issue(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 R11 zero size");
    issue(0, 16385, 0, 0, 0, 0, 0, 0, 0, 0, "R2 oversize");
    issue(0, 16384, 0, 0, 1, 0, 0, 8, 0, 0, "R2 R1 full pool untouched");
    issue(0, 64, 0, 0, 0, 0, 0, 0, 0, 0, "R4 exhausted");
    issue(1, 0, 0, 8, 1, 0, 0, 8, 1, 1, "R4 R8 state unchanged, held rsp");
    issue(0, 8192, 0, 0, 1, 0, 0, 7, 1, 0, "R1 alloc 8192");
    issue(0, 5000, 0, 0, 1, 0, 8192, 7, 0, 0, "R1 R3 alloc 5000");
    issue(0, 64, 0, 0, 0, 0, 0, 0, 0, 0, "R4 exhausted again");

    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule